// File: doc/BRIEF.md
# Alternating Read/Write Start Arbiter

This block sits ahead of a burst memory that can begin only one access per clock and needs two clocks to finish each burst. On every rising edge it looks at a read request and a write request, each with its own address. It then decides whether a read starts, a write starts or nothing starts. When one kind is chosen, it raises that kind's start strobe and passes the matching address to the memory.

The choice depends on what started on the edge before. A kind that has just started may not start again on the next edge. When both requests are present, the block favours the kind that did not start last, and it favours the read when the previous edge started nothing. If both requests are held, the result is a strict read, write, read, write pattern that always opens with a read. A two-bit record of the kind started on the previous edge is registered, and it is also an output.

Top module: `rw_alt_arbiter`

## Requirements
- R1: On any cycle, at most one of `start_rd` and `start_wr` is high.
- R2: If both requests are high and `last_start` is 2'b00 (nothing started on the previous edge), `start_rd` is high.
- R3: If both requests are high and a read started on the previous edge (`last_start` = 2'b01), `start_wr` is high.
- R4: If both requests are high and a write started on the previous edge (`last_start` = 2'b10), `start_rd` is high.
- R5: A read request in the cycle right after a read start is not honoured (`start_rd` low). Likewise, a write request in the cycle right after a write start is not honoured.
- R6: A lone request whose kind did not start on the previous edge is granted in the same cycle.
- R7: A synchronous active-high reset clears the history, so `last_start` reads 2'b00 in the cycle after any edge on which `rst` is high.
- R8: `last_start` is registered at each edge. Bit 0 is set when a read started, bit 1 is set when a write started, and the value is 2'b00 when nothing started. It is never 2'b11.
- R9: `sel_addr` equals `wr_addr` when a write starts, equals `rd_addr` when a read starts, and is zero when nothing starts.
- R10: Holding both requests high from the idle state gives starts of read, write, read, write and so on, with one start on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Address for the requested read |
| wr_req | input | 1 | Write request |
| wr_addr | input | ADDR_W | Address for the requested write |
| start_rd | output | 1 | A read starts on this edge |
| start_wr | output | 1 | A write starts on this edge |
| sel_addr | output | ADDR_W | Address of the access that starts, or zero |
| last_start | output | 2 | Kind started on the previous edge: bit 0 read, bit 1 write |

## Verification
The bench builds the arbiter with `ADDR_W` = 12. This width is wide enough to give the read and write addresses distinct random values, so a wrong choice in the address multiplexer is visible on `sel_addr`. Directed runs cover these cases:
- both requests held from idle;
- back-to-back requests of the same kind;
- a lone request following the other kind;
- a reset in mid-stream.

A long run with random request patterns then brings every history state together with every request combination.

// File: rtl/rwarb_pkg.sv
package rwarb_pkg;

    typedef enum logic [1:0] {
        ST_NONE = 2'b00,
        ST_RD   = 2'b01,
        ST_WR   = 2'b10
    } start_e;

    typedef struct packed {
        logic wr;
        logic rd;
    } grant_t;

    function automatic start_e grant_kind(grant_t g);
        if (g.rd)      return ST_RD;
        else if (g.wr) return ST_WR;
        else           return ST_NONE;
    endfunction

endpackage

// File: rtl/rwarb_history.sv
module rwarb_history
    import rwarb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  start_e nxt_kind,
    output start_e prev_kind
);
    always_ff @(posedge clk) begin
        if (rst) prev_kind <= ST_NONE;
        else     prev_kind <= nxt_kind;
    end
endmodule

// File: rtl/rwarb_decide.sv
module rwarb_decide
    import rwarb_pkg::*;
(
    input  logic   rd_req,
    input  logic   wr_req,
    input  start_e prev_kind,
    output grant_t grant
);
    logic rd_ok;
    logic wr_ok;

    always_comb begin
        rd_ok    = rd_req && (prev_kind != ST_RD);
        wr_ok    = wr_req && (prev_kind != ST_WR);
        grant.rd = rd_ok;
        grant.wr = wr_ok && !rd_ok;
    end
endmodule

// File: rtl/rwarb_addr_sel.sv
module rwarb_addr_sel
    import rwarb_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  grant_t              grant,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [ADDR_W-1:0]   wr_addr,
    output logic [ADDR_W-1:0]   sel_addr
);
    always_comb begin
        unique case (grant_kind(grant))
            ST_RD:   sel_addr = rd_addr;
            ST_WR:   sel_addr = wr_addr;
            default: sel_addr = '0;
        endcase
    end
endmodule

// File: rtl/rw_alt_arbiter.sv
module rw_alt_arbiter
    import rwarb_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              start_rd,
    output logic              start_wr,
    output logic [ADDR_W-1:0] sel_addr,
    output logic [1:0]        last_start
);
    start_e prev_kind;
    start_e nxt_kind;
    grant_t grant;

    rwarb_decide u_decide (
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .prev_kind (prev_kind),
        .grant     (grant)
    );

    assign nxt_kind = grant_kind(grant);

    rwarb_history u_hist (
        .clk       (clk),
        .rst       (rst),
        .nxt_kind  (nxt_kind),
        .prev_kind (prev_kind)
    );

    rwarb_addr_sel #(.ADDR_W(ADDR_W)) u_addr (
        .grant    (grant),
        .rd_addr  (rd_addr),
        .wr_addr  (wr_addr),
        .sel_addr (sel_addr)
    );

    assign start_rd   = grant.rd;
    assign start_wr   = grant.wr;
    assign last_start = prev_kind;

    assert_single_start_R1: assert property (@(posedge clk) disable iff (rst)
        !(start_rd && start_wr));
    assert_idle_read_R2: assert property (@(posedge clk) disable iff (rst)
        (last_start == 2'b00 && rd_req) |-> start_rd);
    assert_after_rd_write_R3: assert property (@(posedge clk) disable iff (rst)
        (last_start == 2'b01 && wr_req) |-> start_wr);
    assert_no_rd_repeat_R5: assert property (@(posedge clk) disable iff (rst)
        start_rd |=> !start_rd);
    assert_no_wr_repeat_R5: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> !start_wr);
    assert_reset_clears_R7: assert property (@(posedge clk)
        rst |=> (last_start == 2'b00));
    assert_record_rd_R8: assert property (@(posedge clk) disable iff (rst)
        start_rd |=> (last_start == 2'b01));
    assert_record_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(last_start));
endmodule

// File: tb/sim_rw_alt_arbiter.sv
module sim_rw_alt_arbiter;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          rd_req, wr_req;
    logic [AW-1:0] rd_addr, wr_addr;
    logic          start_rd, start_wr;
    logic [AW-1:0] sel_addr;
    logic [1:0]    last_start;

    int n_chk  = 0;
    int n_fail = 0;
    int prev   = 0;   // model history: 0 none, 1 read, 2 write
    int rd_seen_cnt, wr_seen_cnt;

    always #5 clk = ~clk;

    rw_alt_arbiter #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_req(wr_req), .wr_addr(wr_addr), .start_rd(start_rd),
        .start_wr(start_wr), .sel_addr(sel_addr), .last_start(last_start)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // drive inputs just after the edge, compare at the falling edge, advance model at next edge
    task automatic step(input logic r, input logic w, input string tag);
        int g;
        @(posedge clk); #1;
        rd_req  = r; wr_req = w;
        rd_addr = AW'($urandom); wr_addr = AW'($urandom);
        @(negedge clk);
        g = 0;
        if (r && prev != 1) g = 1;
        else if (w && prev != 2) g = 2;
        chk({tag, " R8 last_start"}, 32'(last_start),
            (prev == 1) ? 32'd1 : (prev == 2) ? 32'd2 : 32'd0);
        chk({tag, " R1 start_rd"}, 32'(start_rd), 32'(g == 1));
        chk({tag, " R1 start_wr"}, 32'(start_wr), 32'(g == 2));
        chk({tag, " R9 sel_addr"}, 32'(sel_addr),
            (g == 1) ? 32'(rd_addr) : (g == 2) ? 32'(wr_addr) : 32'd0);
        if (g == 1) rd_seen_cnt++;
        if (g == 2) wr_seen_cnt++;
        prev = rst ? 0 : g;
    endtask

    initial begin
        #1_500_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; rd_req = 0; wr_req = 0; rd_addr = '0; wr_addr = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R7 reset last_start", 32'(last_start), 32'd0);
        chk("R7 reset start_rd", 32'(start_rd), 32'd0);
        @(posedge clk); #1; rst = 1'b0; prev = 0;

        // R10 / R2 / R3 / R4: both held from idle
        rd_seen_cnt = 0; wr_seen_cnt = 0;
        for (int i = 0; i < 8; i++) step(1, 1, "R10 alternate");
        chk("R10 read count", 32'(rd_seen_cnt), 32'd4);
        chk("R10 write count", 32'(wr_seen_cnt), 32'd4);

        // R5: repeated read requests
        step(0, 0, "idle");
        step(1, 0, "R5 first read");
        step(1, 0, "R5 repeat read");
        step(1, 0, "R5 read after gap");
        step(0, 1, "R6 write after read");
        step(0, 1, "R5 repeat write");
        step(0, 1, "R5 write after gap");
        step(1, 0, "R6 read after write");
        step(1, 1, "R3 both after read");
        step(1, 1, "R4 both after write");

        // R7: reset mid stream
        step(1, 0, "R7 pre");
        @(posedge clk); #1; rst = 1'b1; rd_req = 0; wr_req = 0;
        @(posedge clk); #1; rst = 1'b0; prev = 0;
        @(negedge clk);
        chk("R7 mid reset last_start", 32'(last_start), 32'd0);
        step(1, 1, "R2 both after reset");

        // random coverage
        for (int i = 0; i < 400; i++)
            step(1'($urandom), 1'($urandom), "random");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule